// File: doc/BRIEF.md
# I2C Block-Write Configuration Slave

This block is the serial configuration port of a clock generator. It sits on a two-wire I2C bus as a slave and holds six 8-bit configuration registers. The rest of the device reads those registers through one flat parallel output. The block samples SCL and SDA with a fast system clock. It pulls SDA low through an open-drain enable whenever it acknowledges a byte or sends a 0 bit.

Only sequential block transfers are supported, and there is no register addressing. A write transfer starts with the device address and the write flag. It carries two bytes that are acknowledged and then thrown away, and after them the register bytes, always starting at register 0 and counting up until STOP. A read transfer starts with the device address and the read flag. The slave then sends a byte count followed by the registers from register 0 upwards, until the master stops acknowledging. A repeated START begins a new transfer from the first byte.

Top module: `cfg_i2c_slave`

## Requirements
- R1: An address byte of 0xD2 (7-bit address 0x69 with the R/W bit 0 in bit 0) is acknowledged: `sda_oe` is 1 during the ninth SCL high phase.
- R2: After a write address, the first two bytes (command and count) are each acknowledged, and their values reach no register.
- R3: Write data bytes go to register 0, 1, 2 … in that order. Register k appears on `cfg_q[8k+7:8k]`. A register changes only after its whole byte has been received. A transfer that ends after any byte leaves the later registers unchanged.
- R4: An address byte of 0xD3 is acknowledged. The slave then sends, MSB first, the value 6 and then registers 0 to 5 in order. Any byte requested after register 5 reads as 0x00.
- R5: While and after reset, `cfg_q` holds 0x00 in register 0 and 0xFF in registers 1 to 5, and `sda_oe` is 0.
- R6: Any other address byte gets no acknowledge. Until the next START the slave neither drives SDA nor writes any register.
- R7: Write data bytes beyond register 5 are acknowledged and discarded.
- R8: A repeated START releases SDA and restarts the byte sequence, so the next write again discards two bytes and then writes from register 0.
- R9: When the master answers a read byte with no acknowledge, the slave releases SDA and sends nothing more in that transfer.
- R10: The slave begins to pull SDA low only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_q | output | 48 | All configuration registers, register k in bits 8k+7:8k |

## Verification
The assertions check on every cycle that registers change only after a committed write, and that no write targets an index past register 5. They also check that SDA starts being pulled only while SCL is low, that a START releases SDA, and that reset restores the defaults. The order of the register writes, the discarding of the two leading bytes, the byte count and readback order, the silence after a wrong address and the end of a read after a NACK are all matters of byte sequence. These can only be shown by the bench's directed and random transfers, which compare against a register model.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [BYTE_W-1:0] reset_value(int idx);
        return (idx == 0) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/cfgi2c_bus_sync.sv
module cfgi2c_bus_sync
    import cfgi2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_level
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.start  = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop   = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise   = scl_s & ~scl_d;
        ev.fall   = ~scl_s & scl_d;
        ev.sda    = sda_s;
        scl_level = scl_s;
    end
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
    import cfgi2c_pkg::*;
#(
    parameter int NREG = 6,
    localparam int IDX_W = idx_width(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NREG*BYTE_W-1:0]   regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] val;
        always_ff @(posedge clk) begin
            if (rst) begin
                val <= reset_value(g);
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                val <= wr_data;
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = val;
    end
endmodule

// File: rtl/cfgi2c_proto.sv
module cfgi2c_proto
    import cfgi2c_pkg::*;
#(
    parameter int         NREG     = 6,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    localparam int IDX_W = idx_width(NREG),
    localparam int CNT_W = $clog2(NREG + 3) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_ev_t                ev,
    input  logic [NREG*BYTE_W-1:0] regs_flat,
    output logic                   sda_oe,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [BYTE_W-1:0]      wr_data
);
    phase_e            ph;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] tx_next;
    logic [3:0]        bitcnt;
    logic [CNT_W-1:0]  bcnt;
    logic [CNT_W-1:0]  data_pos;
    logic [CNT_W-1:0]  rd_pos;
    logic [CNT_W-1:0]  bcnt_inc;
    logic              is_addr;
    logic              rd_mode;
    logic              mnack;

    assign data_pos = bcnt - CNT_W'(2);
    assign rd_pos   = bcnt - CNT_W'(1);
    assign bcnt_inc = (bcnt == '1) ? bcnt : bcnt + 1'b1;

    always_comb begin
        tx_next = '0;
        if (bcnt == '0) begin
            tx_next = BYTE_W'(NREG);
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (rd_pos == CNT_W'(i)) tx_next = regs_flat[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            shreg   <= '0;
            tx_sh   <= '0;
            bitcnt  <= '0;
            bcnt    <= '0;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            mnack   <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                ph      <= PH_RX;
                bitcnt  <= '0;
                bcnt    <= '0;
                is_addr <= 1'b1;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                ph     <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (ph)
                    PH_RX: begin
                        if (ev.rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            if (is_addr) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rd_mode <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    ph      <= PH_RX_ACK;
                                end else begin
                                    ph <= PH_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                ph     <= PH_RX_ACK;
                                if (bcnt >= CNT_W'(2) && data_pos < CNT_W'(NREG)) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= data_pos[IDX_W-1:0];
                                    wr_data <= shreg;
                                end
                                bcnt <= bcnt_inc;
                            end
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            bitcnt  <= '0;
                            is_addr <= 1'b0;
                            if (is_addr && rd_mode) begin
                                ph     <= PH_TX;
                                tx_sh  <= tx_next;
                                sda_oe <= ~tx_next[7];
                                bcnt   <= bcnt_inc;
                            end else begin
                                ph     <= PH_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.fall) begin
                            if (bitcnt == 4'd7) begin
                                ph     <= PH_TX_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) begin
                            mnack <= ev.sda;
                        end else if (ev.fall) begin
                            if (mnack) begin
                                ph <= PH_IDLE;
                            end else begin
                                ph     <= PH_TX;
                                bitcnt <= '0;
                                tx_sh  <= tx_next;
                                sda_oe <= ~tx_next[7];
                                bcnt   <= bcnt_inc;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter int         NREG        = 6,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    localparam int IDX_W = idx_width(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] cfg_q
);
    bus_ev_t           bev;
    logic              scl_seen;
    logic              start_seen;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    cfgi2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .ev        (bev),
        .scl_level (scl_seen)
    );

    assign start_seen = bev.start;

    cfgi2c_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (bev),
        .regs_flat (cfg_q),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfgi2c_regbank #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (cfg_q)
    );
endmodule

// File: rtl/cfgi2c_checker.sv
module cfgi2c_checker
    import cfgi2c_pkg::*;
#(
    parameter int NREG = 6,
    localparam int IDX_W = idx_width(NREG)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_seen,
    input logic                   start_seen,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_idx,
    input logic [NREG*BYTE_W-1:0] cfg_q
);
    logic [NREG*BYTE_W-1:0] dflt;
    always_comb begin
        for (int i = 0; i < NREG; i++) dflt[i*BYTE_W +: BYTE_W] = reset_value(i);
    end

    AST_RESET_DEFAULTS: assert property (@(posedge clk) rst |=> (cfg_q == dflt && !sda_oe)); // R5
    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst) !$stable(cfg_q) |-> $past(wr_en)); // R3
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst) wr_en |-> (wr_idx < IDX_W'(NREG))); // R7
    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_seen); // R10
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst) start_seen |=> !sda_oe); // R8
endmodule

bind cfg_i2c_slave cfgi2c_checker #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_seen   (scl_seen),
    .start_seen (start_seen),
    .sda_oe     (sda_oe),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .cfg_q      (cfg_q)
);

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_i;
    logic        sda_oe;
    logic [47:0] cfg_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] mdl [6];

    always #5 clk = ~clk;

    assign sda_i = ~(m_low | sda_oe);

    cfg_i2c_slave dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_i),
        .sda_oe (sda_oe),
        .cfg_q  (cfg_q)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] model_flat();
        logic [47:0] f;
        for (int i = 0; i < 6; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    function automatic logic [7:0] exp_read(int k);
        if (k == 0) return 8'd6;
        if (k - 1 < 6) return mdl[k-1];
        return 8'h00;
    endfunction

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input bit b);
        m_low = ~b;
        waitc(Q);
        m_scl = 1'b1;
        waitc(Q);
        m_scl = 1'b0;
        waitc(Q);
    endtask

    task automatic rbit(output bit b);
        m_low = 1'b0;
        waitc(Q);
        m_scl = 1'b1;
        waitc(Q / 2);
        b = sda_i;
        waitc(Q / 2);
        m_scl = 1'b0;
        waitc(Q);
    endtask

    task automatic bus_start();
        m_low = 1'b0;
        waitc(Q);
        m_scl = 1'b1;
        waitc(Q);
        m_low = 1'b1;
        waitc(Q);
        m_scl = 1'b0;
        waitc(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1;
        waitc(Q);
        m_scl = 1'b1;
        waitc(Q);
        m_low = 1'b0;
        waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            rbit(x);
            b[i] = x;
        end
        wbit(~give_ack);
    endtask

    task automatic write_xfer(input int n, input logic [7:0] cmd, input logic [7:0] cnt, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, ack);
        check(ack, "R1", 64'(ack), 64'd1);
        send_byte(cmd, ack);
        check(ack, "R2", 64'(ack), 64'd1);
        send_byte(cnt, ack);
        check(ack, "R2", 64'(ack), 64'd1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(ack, (k >= 6) ? "R7" : req, 64'(ack), 64'd1);
            if (k < 6) mdl[k] = d;
        end
        bus_stop();
        waitc(4);
        check(cfg_q == model_flat(), req, 64'(cfg_q), 64'(model_flat()));
    endtask

    task automatic read_xfer(input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack);
        check(ack, "R4", 64'(ack), 64'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(b == exp_read(k), "R4", 64'(b), 64'(exp_read(k)));
        end
        check(sda_oe == 1'b0, "R9", 64'(sda_oe), 64'd0);
        waitc(3 * Q);
        check(sda_oe == 1'b0, "R9", 64'(sda_oe), 64'd0);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] b;
        void'($urandom(32'h5EED_0042));
        mdl[0] = 8'h00;
        for (int i = 1; i < 6; i++) mdl[i] = 8'hFF;
        waitc(6);
        check(cfg_q == model_flat(), "R5", 64'(cfg_q), 64'(model_flat()));
        rst = 1'b0;
        waitc(4);
        check(cfg_q == model_flat(), "R5", 64'(cfg_q), 64'(model_flat()));
        check(sda_oe == 1'b0, "R5", 64'(sda_oe), 64'd0);

        // R5 readback of defaults, then R1/R2/R3 short write
        read_xfer(8);
        write_xfer(2, 8'h5A, 8'h03, "R3");
        read_xfer(4);

        // R6: wrong addresses, trailing bytes unacked and unwritten
        bus_start();
        send_byte(8'hA4, ack);
        check(!ack, "R6", 64'(ack), 64'd0);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'h00, ack);
            check(!ack, "R6", 64'(ack), 64'd0);
        end
        bus_stop();
        waitc(4);
        check(cfg_q == model_flat(), "R6", 64'(cfg_q), 64'(model_flat()));
        bus_start();
        send_byte(8'hD0, ack);
        check(!ack, "R6", 64'(ack), 64'd0);
        bus_stop();

        // R7: more data bytes than registers
        write_xfer(9, 8'h00, 8'h09, "R7");

        // R8: repeated start restarts the sequence
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h01, ack);
        send_byte(8'h02, ack);
        send_byte(8'h11, ack);
        mdl[0] = 8'h11;
        bus_start();
        send_byte(8'hD2, ack);
        check(ack, "R8", 64'(ack), 64'd1);
        send_byte(8'h77, ack);
        send_byte(8'h66, ack);
        send_byte(8'h22, ack);
        mdl[0] = 8'h22;
        bus_stop();
        waitc(4);
        check(cfg_q == model_flat(), "R8", 64'(cfg_q), 64'(model_flat()));

        // R8: repeated start from write into read
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        bus_start();
        send_byte(8'hD3, ack);
        check(ack, "R8", 64'(ack), 64'd1);
        recv_byte(1'b0, b);
        check(b == 8'd6, "R8", 64'(b), 64'd6);
        bus_stop();

        // R3/R4: random transfers against the model
        for (int it = 0; it < 24; it++) begin
            write_xfer(int'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), "R3");
            if (it % 4 == 3) read_xfer(int'($urandom_range(1, 8)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule